// File: doc/BRIEF.md
# Frame-Sync PCM Serial Port with Long/Short Sync Detection

This block is the serial side of a voice codec. It carries one 8-bit companded sample per frame in each direction. The transmit direction and the receive direction each have a bit clock and a frame-sync line. All of these are sampled in the system clock domain. The system clock must be several times faster than the fastest bit clock. Frames start on each rising edge of frame sync.

For every frame, the block counts the bit-clock falling edges on which frame sync is seen high. One such edge marks a short sync pulse. Two or more mark a long sync pulse. The result sets the timing of the next frame on that direction: the edge on which transmit data starts, the edge on which the output goes back to high impedance, and the falling edges on which receive data is taken. The transmit byte is taken from a parallel input at each frame start. The received byte appears on a parallel output together with a one-cycle strobe. A power-up input holds the output in high impedance, and the output stays quiet for two whole frames after power returns.

Falling edge number k of a frame is counted from e0. The edge e0 is the first bit-clock falling edge after the frame-sync rising edge on which sync is high.

Top module: `pcm_frame_port`

## Requirements
- R1: A frame whose sync is high on two or more consecutive bit-clock falling edges is classed long. A frame whose sync is high on exactly one falling edge is classed short.
- R2: Each frame is timed by the class of the previous frame's sync pulse on the same direction. The first frame after reset is timed as short.
- R3: Short timing, transmit: tx_oe rises and the MSB is driven from the first bit-clock rising edge after e0. Each later rising edge moves to the next bit, MSB first.
- R4: Short timing, transmit: tx_oe falls at e8, which is the middle of the LSB.
- R5: Long timing, transmit: tx_oe rises with the MSB at the frame-sync rising edge. The following bits change on the rising edges after e0 through e6.
- R6: Long timing, transmit: tx_oe stays high while frame sync is high. It falls at whichever comes later, e7 or the fall of frame sync.
- R7: Receive data is captured on bit-clock falling edges only, MSB first. Short timing uses e1 to e8. Long timing uses e0 to e7.
- R8: After the eighth capture, rx_word holds the byte and rx_word_stb is high for exactly one clock. No strobe is given while pwr_up is low.
- R9: tx_word is latched at the frame-sync rising edge. Changing it later in the frame does not change the bits sent in that frame.
- R10: After reset, and after any period with pwr_up low, tx_oe stays low for the first two frames. Driving resumes in the third frame.
- R11: pwr_up low forces tx_oe low on the next clock.
- R12: Bit-clock edges after the eighth data bit are ignored. There is one received byte per frame, whatever the bit-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up | input | 1 | High to operate; low forces the output quiet |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Byte to send, latched at frame start |
| tx_sdata | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for tx_sdata; low means high impedance |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Serial receive data |
| rx_word | output | 8 | Last complete received byte |
| rx_word_stb | output | 1 | One-cycle strobe when rx_word is updated |

## Verification
The bench drives sync pulses that are high for one, two, three and ten falling edges. The one-edge and two-edge pulses separate the short and long timings. The three-edge pulse checks that a long sync falling before the LSB still ends driving at e7. The ten-edge pulse checks that the output is held past the LSB until sync falls.

Changes of pulse class are placed so that every switch frame must still use the previous class. Each received stream is ten bits long, so a capture window shifted by one edge returns a different byte. The transmit byte is also inverted in mid-frame to show that it is latched at frame start. A power-down in mid-frame checks both the immediate silence of the output and the two-frame quiet period that follows.

// File: rtl/pcm_port_pkg.sv
// Shared types for the frame-sync PCM serial port.
// Assumes: nothing beyond the 1800-2017 language.
package pcm_port_pkg;
    // Frame timing class decided from a sync pulse
    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } sync_fmt_e;
endpackage

// File: rtl/pcm_in_sync.sv
// Multi-stage synchronizer for a group of slow asynchronous lines.
// Assumes: every line is held for many system clocks, so skew between
// lines of the group does not matter.
module pcm_in_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the raw lines through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pcm_frame_track.sv
// Frame tracker for one direction. Finds the bit-clock edges and the
// frame-sync rising edge, numbers the falling edges from e0, and classes
// each sync pulse as long or short. The class of one pulse is applied to
// the next frame.
// Assumes: synchronized inputs; the system clock is at least 4x the bit clock.
module pcm_frame_track
    import pcm_port_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             fs_s,
    output logic             fall_evt,
    output logic             rise_evt,
    output logic             fs_rise_evt,
    output logic             frame_on,
    output logic [IDX_W-1:0] fall_idx,
    output sync_fmt_e        fmt
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic       bclk_d, fs_d, armed;
    logic [1:0] hi_cnt;
    logic       fall_now, rise_now, fsr_now;

    // Detect edges from one-cycle-old copies
    always_comb begin
        fall_now = bclk_d & ~bclk_s;
        rise_now = ~bclk_d & bclk_s;
        fsr_now  = fs_s & ~fs_d;
    end

    // Track edges, edge index and the sync pulse class
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d      <= 1'b0;
            fs_d        <= 1'b0;
            fall_evt    <= 1'b0;
            rise_evt    <= 1'b0;
            fs_rise_evt <= 1'b0;
            frame_on    <= 1'b0;
            armed       <= 1'b0;
            hi_cnt      <= 2'd0;
            fall_idx    <= '0;
            fmt         <= FMT_SHORT;
        end else begin
            bclk_d      <= bclk_s;
            fs_d        <= fs_s;
            fall_evt    <= fall_now;
            rise_evt    <= rise_now;
            fs_rise_evt <= fsr_now;
            if (fsr_now) begin
                armed    <= 1'b1;
                frame_on <= 1'b0;
                hi_cnt   <= 2'd0;
                fmt      <= (hi_cnt == 2'd2) ? FMT_LONG : FMT_SHORT;
            end else if (fall_now) begin
                if (fs_s && hi_cnt != 2'd2) hi_cnt <= hi_cnt + 2'd1;
                if (fs_s && armed) begin
                    armed    <= 1'b0;
                    frame_on <= 1'b1;
                    fall_idx <= '0;
                end else if (frame_on && fall_idx != IDX_MAX) begin
                    fall_idx <= fall_idx + 1'b1;
                end
            end
        end
    end

    // R1
    fmt_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt != $past(fmt)) |-> fs_rise_evt);

    // R12
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_idx != $past(fall_idx)) |-> fall_evt);
endmodule

// File: rtl/pcm_tx_shift.sv
// Transmit serializer. Latches the word at frame start, shifts it out
// MSB first on bit-clock rising edges, and controls the output enable for
// the short or long timing. Holds the output quiet for GUARD frames after
// power returns.
// Assumes: event inputs come from pcm_frame_track of the transmit side.
module pcm_tx_shift
    import pcm_port_pkg::*;
#(
    parameter int W     = 8,
    parameter int GUARD = 2,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_up,
    input  logic [W-1:0]     word,
    input  logic             fs_s,
    input  logic             fall_evt,
    input  logic             rise_evt,
    input  logic             fs_rise_evt,
    input  logic             frame_on,
    input  logic [IDX_W-1:0] fall_idx,
    input  sync_fmt_e        fmt,
    output logic             sdata,
    output logic             oe
);
    localparam int GW = $clog2(GUARD + 1);
    localparam logic [GW-1:0]    GUARD_FULL = GW'(GUARD);
    localparam logic [IDX_W-1:0] LSB_SHORT  = IDX_W'(W);
    localparam logic [IDX_W-1:0] LSB_LONG   = IDX_W'(W - 1);

    logic [W-1:0]  sh;
    logic          drv, live, lsb_done, fs_q;
    logic [GW-1:0] guard;
    sync_fmt_e     mode;

    // Serialize the word and manage the output window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            drv      <= 1'b0;
            live     <= 1'b0;
            lsb_done <= 1'b0;
            guard    <= '0;
            mode     <= FMT_SHORT;
            fs_q     <= 1'b0;
        end else begin
            fs_q <= fs_s;
            if (!pwr_up) begin
                drv   <= 1'b0;
                live  <= 1'b0;
                guard <= '0;
            end else if (fs_rise_evt) begin
                lsb_done <= 1'b0;
                mode     <= fmt;
                sh       <= word;
                if (guard == GUARD_FULL) begin
                    live <= 1'b1;
                    drv  <= (fmt == FMT_LONG);
                end else begin
                    live  <= 1'b0;
                    drv   <= 1'b0;
                    guard <= guard + GW'(1);
                end
            end else begin
                if (rise_evt && live && frame_on) begin
                    if (mode == FMT_SHORT) begin
                        if (fall_idx == '0) drv <= 1'b1;
                        else if (fall_idx < LSB_SHORT) sh <= {sh[W-2:0], 1'b0};
                    end else if (fall_idx < LSB_LONG) begin
                        sh <= {sh[W-2:0], 1'b0};
                    end
                end
                if (fall_evt && frame_on &&
                    fall_idx == ((mode == FMT_LONG) ? LSB_LONG : LSB_SHORT))
                    lsb_done <= 1'b1;
                if (mode == FMT_SHORT && fall_evt && frame_on && fall_idx == LSB_SHORT)
                    drv <= 1'b0;
                if (mode == FMT_LONG && lsb_done && !fs_q)
                    drv <= 1'b0;
            end
        end
    end

    assign sdata = sh[W-1];
    assign oe    = drv;

    // R11
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> !oe);

    // R10
    guard_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (guard == GUARD_FULL));

    // R3
    short_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oe) && mode == FMT_SHORT) |-> $past(rise_evt));

    // R5
    long_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oe) && mode == FMT_LONG) |-> $past(fs_rise_evt));

    // R6
    long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && mode == FMT_LONG && fs_q && pwr_up && !fs_rise_evt) |=> oe);
endmodule

// File: rtl/pcm_rx_shift.sv
// Receive deserializer. Captures eight bits on bit-clock falling edges in
// the window set by the frame's timing class. Presents the byte with a
// one-cycle strobe.
// Assumes: event inputs come from pcm_frame_track of the receive side.
module pcm_rx_shift
    import pcm_port_pkg::*;
#(
    parameter int W     = 8,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_up,
    input  logic             sdata_s,
    input  logic             fall_evt,
    input  logic             rise_evt,
    input  logic             fs_rise_evt,
    input  logic             frame_on,
    input  logic [IDX_W-1:0] fall_idx,
    input  sync_fmt_e        fmt,
    output logic [W-1:0]     word,
    output logic             word_stb
);
    localparam logic [IDX_W-1:0] FIRST_SHORT = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST_SHORT  = IDX_W'(W);
    localparam logic [IDX_W-1:0] FIRST_LONG  = '0;
    localparam logic [IDX_W-1:0] LAST_LONG   = IDX_W'(W - 1);

    logic [W-1:0]     sh;
    logic             rd_q;
    logic [IDX_W-1:0] first, last;

    // Pick the capture window for the current frame class
    always_comb begin
        first = (fmt == FMT_LONG) ? FIRST_LONG : FIRST_SHORT;
        last  = (fmt == FMT_LONG) ? LAST_LONG  : LAST_SHORT;
    end

    // Capture bits in the window and publish the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rd_q     <= 1'b0;
            word     <= '0;
            word_stb <= 1'b0;
        end else begin
            rd_q     <= sdata_s;
            word_stb <= 1'b0;
            if (fs_rise_evt) begin
                sh <= '0;
            end else if (fall_evt && frame_on && fall_idx >= first && fall_idx <= last) begin
                sh <= {sh[W-2:0], rd_q};
                if (fall_idx == last) begin
                    word     <= {sh[W-2:0], rd_q};
                    word_stb <= pwr_up;
                end
            end
        end
    end

    // R8
    stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> ($past(fall_evt) && $past(pwr_up)));

    // R7
    rise_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt && !fs_rise_evt) |=> $stable(sh));
endmodule

// File: rtl/pcm_frame_port.sv
// Top of the frame-sync PCM serial port. Synchronizes the serial lines,
// runs one frame tracker per direction, and feeds the transmit serializer
// and the receive deserializer.
// Assumes: the system clock is at least 8x the faster bit clock.
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int GUARD       = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_up,
    input  logic         tx_bclk,
    input  logic         tx_fsync,
    input  logic [W-1:0] tx_word,
    output logic         tx_sdata,
    output logic         tx_oe,
    input  logic         rx_bclk,
    input  logic         rx_fsync,
    input  logic         rx_sdata,
    output logic [W-1:0] rx_word,
    output logic         rx_word_stb
);
    localparam int IDX_W = $clog2(W + 3) + 1;

    logic [4:0] raw_lines, syn_lines;
    logic t_bclk_s, t_fs_s, r_bclk_s, r_fs_s, r_dat_s;

    logic             t_fall, t_rise, t_fsr, t_on;
    logic [IDX_W-1:0] t_idx;
    sync_fmt_e        t_fmt;
    logic             r_fall, r_rise, r_fsr, r_on;
    logic [IDX_W-1:0] r_idx;
    sync_fmt_e        r_fmt;

    assign raw_lines = {tx_bclk, tx_fsync, rx_bclk, rx_fsync, rx_sdata};
    assign {t_bclk_s, t_fs_s, r_bclk_s, r_fs_s, r_dat_s} = syn_lines;

    pcm_in_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(syn_lines));

    pcm_frame_track #(.IDX_W(IDX_W)) u_tx_trk (
        .clk(clk), .rst_n(rst_n), .bclk_s(t_bclk_s), .fs_s(t_fs_s),
        .fall_evt(t_fall), .rise_evt(t_rise), .fs_rise_evt(t_fsr),
        .frame_on(t_on), .fall_idx(t_idx), .fmt(t_fmt));

    pcm_frame_track #(.IDX_W(IDX_W)) u_rx_trk (
        .clk(clk), .rst_n(rst_n), .bclk_s(r_bclk_s), .fs_s(r_fs_s),
        .fall_evt(r_fall), .rise_evt(r_rise), .fs_rise_evt(r_fsr),
        .frame_on(r_on), .fall_idx(r_idx), .fmt(r_fmt));

    pcm_tx_shift #(.W(W), .GUARD(GUARD), .IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .word(tx_word),
        .fs_s(t_fs_s), .fall_evt(t_fall), .rise_evt(t_rise),
        .fs_rise_evt(t_fsr), .frame_on(t_on), .fall_idx(t_idx), .fmt(t_fmt),
        .sdata(tx_sdata), .oe(tx_oe));

    pcm_rx_shift #(.W(W), .IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .sdata_s(r_dat_s),
        .fall_evt(r_fall), .rise_evt(r_rise), .fs_rise_evt(r_fsr),
        .frame_on(r_on), .fall_idx(r_idx), .fmt(r_fmt),
        .word(rx_word), .word_stb(rx_word_stb));
endmodule

// File: tb/pcm_frame_port_test.sv
`timescale 1ns/1ps
module pcm_frame_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_up = 1'b1;
    logic       bclk = 1'b1;
    logic       fs = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_sdata, tx_oe, rx_word_stb;
    logic [7:0] rx_word;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  prev_long = 1'b0;
    int  frames_up = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    pcm_frame_port uut (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
        .tx_bclk(bclk), .tx_fsync(fs), .tx_word(tx_word),
        .tx_sdata(tx_sdata), .tx_oe(tx_oe),
        .rx_bclk(bclk), .rx_fsync(fs), .rx_sdata(rd),
        .rx_word(rx_word), .rx_word_stb(rx_word_stb));

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops expected bytes as strobes appear (R7, R8, R12)
    always @(negedge clk) begin
        if (rst_n && rx_word_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 extra strobe", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_word == e, "R7 R8 rx byte", rx_word, e);
            end
        end
    end

    // One frame: sync high for hi falls, stream s (bit at e_k is s[9-k])
    task automatic do_frame(input int hi, input logic [7:0] w, input logic [9:0] s,
                            input bit scr, input bit drop);
        bit    pred = prev_long;
        bit    ok   = (frames_up >= 2);
        bit    live = 1'b1;
        string tag;
        if (scr) tag = "R9";
        else if (pred != (hi >= 2)) tag = "R2";
        else if (pred) tag = "R1 R5";
        else tag = "R1 R3";
        tx_word = w;
        if (!drop) exp_q.push_back(pred ? s[9:2] : s[8:1]);
        for (int p = -1; p <= 10; p++) begin
            for (int c = 0; c < 24; c++) begin
                if (c == 0) bclk = 1'b0;
                if (c == 12) bclk = 1'b1;
                if (p == -1 && c == 6) fs = 1'b1;
                if (p == hi - 1 && c == 6) fs = 1'b0;
                if (c == 18 && p <= 8) rd = s[8-p];
                if (scr && p == 3 && c == 0) tx_word = ~w;
                if (drop && p == 4 && c == 0) begin pwr_up = 1'b0; live = 1'b0; end
                if (drop && p == 4 && c == 4) check(tx_oe == 1'b0, "R11 oe", tx_oe, 0);
                if (live && ok) begin
                    if (!pred) begin
                        if (p == -1 && c == 22) check(tx_oe == 1'b0, "R3 quiet before e0", tx_oe, 0);
                        if (p >= 0 && p <= 7 && c == 22)
                            check(tx_oe && tx_sdata == w[7-p], tag, {tx_oe, tx_sdata}, {1'b1, w[7-p]});
                        if (p == 8 && c == 10) check(tx_oe == 1'b0, "R4 release", tx_oe, 0);
                    end else begin
                        if (p == -1 && c == 22)
                            check(tx_oe && tx_sdata == w[7], tag, {tx_oe, tx_sdata}, {1'b1, w[7]});
                        if (p >= 0 && p <= 6 && c == 22)
                            check(tx_oe && tx_sdata == w[6-p], tag, {tx_oe, tx_sdata}, {1'b1, w[6-p]});
                        if (hi <= 8 && p == 7 && c == 10) check(tx_oe == 1'b0, "R6 release", tx_oe, 0);
                        if (hi > 9 && p == 8 && c == 10) check(tx_oe == 1'b1, "R6 hold", tx_oe, 1);
                        if (hi > 9 && p == 9 && c == 22) check(tx_oe == 1'b0, "R6 late release", tx_oe, 0);
                    end
                end
                if (!ok && c == 22 && (p == 0 || p == 4))
                    check(tx_oe == 1'b0, "R10 guard", tx_oe, 0);
                @(negedge clk);
            end
        end
        prev_long = (hi >= 2);
        if (drop) begin
            pwr_up = 1'b1;
            frames_up = 0;
        end else begin
            frames_up++;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_oe == 1'b0, "R10 reset oe", tx_oe, 0);
        check(rx_word_stb == 1'b0, "R8 reset stb", rx_word_stb, 0);
        do_frame(1,  8'h5A, 10'h2B3, 0, 0);
        do_frame(1,  8'h81, 10'h1C4, 0, 0);
        do_frame(1,  8'hA5, 10'h3A6, 0, 0);
        do_frame(1,  8'h3C, 10'h0F1, 1, 0);
        do_frame(2,  8'hC3, 10'h255, 0, 0);
        do_frame(2,  8'h96, 10'h1AA, 0, 0);
        do_frame(10, 8'h71, 10'h30C, 0, 0);
        do_frame(3,  8'hE8, 10'h0D7, 1, 0);
        do_frame(1,  8'h2D, 10'h39B, 0, 0);
        do_frame(1,  8'hB4, 10'h164, 0, 0);
        do_frame(2,  8'h6E, 10'h2E9, 0, 1);
        do_frame(2,  8'h4F, 10'h13E, 0, 0);
        do_frame(1,  8'hD2, 10'h271, 0, 0);
        do_frame(1,  8'h19, 10'h0AB, 0, 0);
        do_frame(3,  8'hF0, 10'h356, 0, 0);
        do_frame(2,  8'h0F, 10'h1D9, 0, 0);
        do_frame(1,  8'h77, 10'h2A2, 0, 0);
        repeat (300) @(negedge clk);
        check(exp_q.size() == 0, "R8 missing strobe", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule